// File: doc/BRIEF.md
# Scalar Register ALU Executor

This block executes a small family of 32-bit scalar instructions against a private register bank held for each hardware thread. Three instruction classes are supported: logical shifts, bitwise logic (AND, OR, XOR) and unsigned comparison. An instruction word and a thread number arrive on a valid/ready handshake. The block decodes the word, fetches one or two source operands from the selected thread's 64 x 32-bit bank (or takes a small constant from the instruction word in place of the second operand), computes the result and writes it back to the destination register of the same thread.

Only one instruction is in flight at a time. The occupancy is either three or four cycles. An instruction takes three cycles when its second operand is a constant, or when both source indices fall in the same aligned group of four registers; otherwise it takes four. Completion is signalled by a one-cycle `done` pulse. An instruction with an undefined select value or an unknown opcode completes with an `illegal` pulse and writes nothing. A combinational debug read port exposes any register of any thread.

Top module: `sreg_alu_exec`

## Requirements
- R1: Fields are taken from fixed bit positions: opcode [31:24] (0x5B bitwise, 0x5C shift, 0x5D compare), constant-operand flag [23], operation select [20:18], destination index [17:12], operand-B index or constant [11:6], operand-A index [5:0]. Bits [22:21] are not decoded.
- R2: Bitwise select 0 writes A AND B, select 1 writes A OR B, select 2 writes A XOR B.
- R3: Shift select 0 writes A shifted left with only the low 32 bits kept; select 1 writes A shifted right logically. The shift amount is the low 5 bits of operand B, whether B is a register value or the constant field.
- R4: When bit 23 is set for a bitwise or compare instruction, operand B is the 6-bit field [11:6] zero-extended to 32 bits.
- R5: Compare select 0 tests A > B, select 1 tests A < B and select 2 tests A == B, all unsigned. The destination receives 1 when the test holds and 0 otherwise.
- R6: Counting the accept edge as cycle 0, `done` is high during cycle L, where L is 3 if bit 23 is set or A[5:2] equals B[5:2], and 4 otherwise. `done` is never high in cycles 1 or 2. The written value is visible on the debug port from the cycle after `done`.
- R7: `in_ready` is low from the cycle after an accept until the `done` cycle, and high during the `done` cycle. An instruction accepted in the `done` cycle sees the register value just written.
- R8: A select value above 2 for bitwise or compare, above 1 for shift, or an opcode other than the three above, makes `illegal` high together with `done`, and leaves every register unchanged.
- R9: The thread number picks the register bank. An instruction reads and writes only its own thread's bank.
- R10: Reset clears every register of every bank to zero, sets `in_ready` high and holds `done` and `illegal` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Block can take an instruction this cycle |
| in_instr | input | 32 | Instruction word |
| in_tid | input | TID_W | Thread number of the offered instruction |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Completing instruction was undefined; no write |
| dbg_tid | input | TID_W | Debug read thread |
| dbg_idx | input | 6 | Debug read register index |
| dbg_data | output | 32 | Contents of the selected register |

## Verification
On every cycle the assertions check that the block drops `in_ready` right after an accept, that `done` cannot come in the first two cycles of an instruction, that `illegal` only appears on a `done` cycle, and that a legal compare produces a 0-or-1 value. Arithmetic results, the exact three-versus-four cycle choice from register grouping, the truncation of shift amounts and constants, the separation of thread banks and the absence of writes on illegal instructions are only shown by the bench's vectors and directed scenarios, which read the banks back through the debug port.

// File: rtl/sralu_pkg.sv
package sralu_pkg;

  localparam int IDX_W    = 6;
  localparam int NUM_REGS = 1 << IDX_W;
  localparam int GRP_LSB  = 2;           // aligned groups of four registers
  localparam int CNT_W    = 3;
  localparam int LAT_FAST = 3;
  localparam int LAT_SLOW = 4;

  localparam logic [7:0] OPC_BITW  = 8'h5B;
  localparam logic [7:0] OPC_SHIFT = 8'h5C;
  localparam logic [7:0] OPC_CMP   = 8'h5D;

  typedef enum logic [1:0] {
    CLS_BITW  = 2'd0,
    CLS_SHIFT = 2'd1,
    CLS_CMP   = 2'd2,
    CLS_NONE  = 2'd3
  } op_class_e;

  typedef struct packed {
    op_class_e        cls;
    logic [2:0]       sel;
    logic             use_const;
    logic [IDX_W-1:0] dst;
    logic [IDX_W-1:0] b_fld;
    logic [IDX_W-1:0] a_fld;
    logic             bad;
    logic             slow;
  } dec_t;

endpackage

// File: rtl/sralu_decode.sv
module sralu_decode
  import sralu_pkg::*;
(
  input  logic [31:0] instr,
  output dec_t        dec
);

  logic [7:0] opc;
  logic       sel_ok;
  logic       unused_rsvd;

  assign opc         = instr[31:24];
  assign unused_rsvd = ^instr[22:21];

  always_comb begin
    dec           = '0;
    dec.use_const = instr[23];
    dec.sel       = instr[20:18];
    dec.dst       = instr[17:12];
    dec.b_fld     = instr[11:6];
    dec.a_fld     = instr[5:0];

    case (opc)
      OPC_BITW:  dec.cls = CLS_BITW;
      OPC_SHIFT: dec.cls = CLS_SHIFT;
      OPC_CMP:   dec.cls = CLS_CMP;
      default:   dec.cls = CLS_NONE;
    endcase

    case (dec.cls)
      CLS_BITW,
      CLS_CMP:   sel_ok = (dec.sel <= 3'd2);
      CLS_SHIFT: sel_ok = (dec.sel <= 3'd1);
      default:   sel_ok = 1'b0;
    endcase
    dec.bad = !sel_ok;

    // fast path: constant operand or both sources in one group of four
    dec.slow = !dec.use_const &&
               (dec.a_fld[IDX_W-1:GRP_LSB] != dec.b_fld[IDX_W-1:GRP_LSB]);
  end

endmodule

// File: rtl/sralu_regbank.sv
module sralu_regbank
  import sralu_pkg::*;
#(
  parameter int NUM_THREADS = 2,
  parameter int DATA_W      = 32,
  parameter int TID_W       = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TID_W-1:0]  rd_tid,
  input  logic [IDX_W-1:0]  ra_idx,
  input  logic [IDX_W-1:0]  rb_idx,
  output logic [DATA_W-1:0] ra_data,
  output logic [DATA_W-1:0] rb_data,
  input  logic              wr_en,
  input  logic [TID_W-1:0]  wr_tid,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [TID_W-1:0]  dbg_tid,
  input  logic [IDX_W-1:0]  dbg_idx,
  output logic [DATA_W-1:0] dbg_data
);

  localparam int ADDR_W = TID_W + IDX_W;
  localparam int TOTAL  = 1 << ADDR_W;

  logic [DATA_W-1:0] ent [TOTAL];

  for (genvar t = 0; t < (1 << TID_W); t++) begin : g_thr
    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
      if (t < NUM_THREADS) begin : g_live
        logic              hit;
        logic [DATA_W-1:0] q;
        assign hit = wr_en && (wr_tid == TID_W'(t)) && (wr_idx == IDX_W'(r));
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)   q <= '0;
          else if (hit) q <= wr_data;
        end
        assign ent[t*NUM_REGS + r] = q;
      end else begin : g_hole
        assign ent[t*NUM_REGS + r] = '0;
      end
    end
  end

  assign ra_data  = ent[{rd_tid, ra_idx}];
  assign rb_data  = ent[{rd_tid, rb_idx}];
  assign dbg_data = ent[{dbg_tid, dbg_idx}];

endmodule

// File: rtl/sralu_compute.sv
module sralu_compute
  import sralu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  op_class_e         cls,
  input  logic [2:0]        sel,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  output logic [DATA_W-1:0] res
);

  localparam int SHAMT_W = $clog2(DATA_W);

  logic [SHAMT_W-1:0] amt;
  assign amt = opb[SHAMT_W-1:0];

  always_comb begin
    res = '0;
    case (cls)
      CLS_BITW: begin
        case (sel)
          3'd0:    res = opa & opb;
          3'd1:    res = opa | opb;
          3'd2:    res = opa ^ opb;
          default: res = '0;
        endcase
      end
      CLS_SHIFT: begin
        case (sel)
          3'd0:    res = opa << amt;
          3'd1:    res = opa >> amt;
          default: res = '0;
        endcase
      end
      CLS_CMP: begin
        case (sel)
          3'd0:    res = DATA_W'(opa > opb);
          3'd1:    res = DATA_W'(opa < opb);
          3'd2:    res = DATA_W'(opa == opb);
          default: res = '0;
        endcase
      end
      default: res = '0;
    endcase
  end

endmodule

// File: rtl/sreg_alu_exec.sv
module sreg_alu_exec
  import sralu_pkg::*;
#(
  parameter int NUM_THREADS = 2,
  parameter int DATA_W      = 32,
  localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [31:0]       in_instr,
  input  logic [TID_W-1:0]  in_tid,
  output logic              done,
  output logic              illegal,
  input  logic [TID_W-1:0]  dbg_tid,
  input  logic [IDX_W-1:0]  dbg_idx,
  output logic [DATA_W-1:0] dbg_data
);

  dec_t              dec_in;
  dec_t              ins_q,  ins_d;
  logic [TID_W-1:0]  tid_q,  tid_d;
  logic              busy_q, busy_d;
  logic [CNT_W-1:0]  cnt_q,  cnt_d;
  logic [DATA_W-1:0] res_q,  res_d;
  logic [DATA_W-1:0] ra_data, rb_data, opb, alu_res;
  logic              accept, cap_res, wr_en;
  logic [CNT_W-1:0]  lat_tgt;

  sralu_decode u_dec (
    .instr (in_instr),
    .dec   (dec_in)
  );

  sralu_regbank #(
    .NUM_THREADS (NUM_THREADS),
    .DATA_W      (DATA_W),
    .TID_W       (TID_W)
  ) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_tid   (tid_q),
    .ra_idx   (ins_q.a_fld),
    .rb_idx   (ins_q.b_fld),
    .ra_data  (ra_data),
    .rb_data  (rb_data),
    .wr_en    (wr_en),
    .wr_tid   (tid_q),
    .wr_idx   (ins_q.dst),
    .wr_data  (res_q),
    .dbg_tid  (dbg_tid),
    .dbg_idx  (dbg_idx),
    .dbg_data (dbg_data)
  );

  // constant operand is zero-extended; shifts take its low bits later
  assign opb = ins_q.use_const ? DATA_W'(ins_q.b_fld) : rb_data;

  sralu_compute #(
    .DATA_W (DATA_W)
  ) u_alu (
    .cls (ins_q.cls),
    .sel (ins_q.sel),
    .opa (ra_data),
    .opb (opb),
    .res (alu_res)
  );

  assign lat_tgt  = ins_q.slow ? CNT_W'(LAT_SLOW) : CNT_W'(LAT_FAST);
  assign done     = busy_q && (cnt_q == lat_tgt);
  assign illegal  = done && ins_q.bad;
  assign wr_en    = done && !ins_q.bad;
  assign in_ready = !busy_q || done;
  assign accept   = in_valid && in_ready;
  assign cap_res  = busy_q && (cnt_q == CNT_W'(1));

  always_comb begin
    ins_d  = ins_q;
    tid_d  = tid_q;
    busy_d = busy_q;
    cnt_d  = cnt_q;
    res_d  = res_q;
    if (busy_q) cnt_d = cnt_q + CNT_W'(1);
    if (cap_res) res_d = alu_res;
    if (done) busy_d = 1'b0;
    if (accept) begin
      ins_d  = dec_in;
      tid_d  = in_tid;
      busy_d = 1'b1;
      cnt_d  = CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ins_q  <= '0;
      tid_q  <= '0;
      busy_q <= 1'b0;
      cnt_q  <= '0;
      res_q  <= '0;
    end else begin
      ins_q  <= ins_d;
      tid_q  <= tid_d;
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      res_q  <= res_d;
    end
  end

  // R7: once an instruction is taken the block stops taking more
  a_r7_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R6: completion never comes in the first cycle after accept
  a_r6_no_done_cycle1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !done);

  // R6: nor in the second
  a_r6_no_done_cycle2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> ##1 !done);

  // R8: the illegal flag is only raised on a completion cycle
  a_r8_illegal_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> done);

  // R5: a legal compare writes a single-bit truth value
  a_r5_cmp_boolean: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !illegal && ins_q.cls == CLS_CMP) |-> (res_q[DATA_W-1:1] == '0));

endmodule

// File: tb/tb_sreg_alu_exec.sv
module tb_sreg_alu_exec;

  localparam int TW = 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic          in_ready;
  logic [31:0]   in_instr;
  logic [TW-1:0] in_tid;
  logic          done;
  logic          illegal;
  logic [TW-1:0] dbg_tid;
  logic [5:0]    dbg_idx;
  logic [31:0]   dbg_data;

  int nchk = 0;
  int nerr = 0;

  always #5 clk = ~clk;

  sreg_alu_exec dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_instr (in_instr),
    .in_tid   (in_tid),
    .done     (done),
    .illegal  (illegal),
    .dbg_tid  (dbg_tid),
    .dbg_idx  (dbg_idx),
    .dbg_data (dbg_data)
  );

  // {op[8], sel[3], const[1], same_group[1], a[32], b[32], expected[32]}
  localparam int NV = 16;
  localparam logic [108:0] VEC [NV] = '{
    {8'h5B, 3'd0, 1'b0, 1'b1, 32'hF0F0_1234, 32'h0FF0_FF00, 32'h00F0_1200},
    {8'h5B, 3'd1, 1'b0, 1'b0, 32'h8000_0001, 32'h0000_0100, 32'h8000_0101},
    {8'h5B, 3'd2, 1'b0, 1'b1, 32'hFFFF_0000, 32'h0F0F_0F0F, 32'hF0F0_0F0F},
    {8'h5B, 3'd0, 1'b1, 1'b0, 32'hFFFF_FFFF, 32'h0000_002A, 32'h0000_002A},
    {8'h5B, 3'd2, 1'b1, 1'b0, 32'h1234_5678, 32'h0000_003F, 32'h1234_5647},
    {8'h5C, 3'd0, 1'b1, 1'b0, 32'h8765_4321, 32'h0000_0004, 32'h7654_3210},
    {8'h5C, 3'd1, 1'b1, 1'b0, 32'h8000_0000, 32'h0000_001F, 32'h0000_0001},
    {8'h5C, 3'd0, 1'b0, 1'b0, 32'h0000_00FF, 32'h0000_0024, 32'h0000_0FF0},
    {8'h5C, 3'd1, 1'b0, 1'b1, 32'h1234_5678, 32'hFFFF_FFE8, 32'h0012_3456},
    {8'h5C, 3'd0, 1'b1, 1'b0, 32'h8000_0003, 32'h0000_0021, 32'h0000_0006},
    {8'h5D, 3'd0, 1'b0, 1'b1, 32'h8000_0000, 32'h7FFF_FFFF, 32'h0000_0001},
    {8'h5D, 3'd1, 1'b0, 1'b0, 32'h8000_0000, 32'h7FFF_FFFF, 32'h0000_0000},
    {8'h5D, 3'd2, 1'b0, 1'b0, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 32'h0000_0001},
    {8'h5D, 3'd1, 1'b1, 1'b0, 32'h0000_0005, 32'h0000_003F, 32'h0000_0001},
    {8'h5D, 3'd0, 1'b1, 1'b0, 32'h0000_0040, 32'h0000_003F, 32'h0000_0001},
    {8'h5D, 3'd2, 1'b1, 1'b0, 32'h0000_003F, 32'h0000_003F, 32'h0000_0001}
  };

  function automatic logic [31:0] enc(logic [7:0] op, logic c, logic [2:0] s,
                                      logic [5:0] d, logic [5:0] b, logic [5:0] a);
    return {op, c, 2'b00, s, d, b, a};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic peek(logic [TW-1:0] t, logic [5:0] r, output logic [31:0] v);
    dbg_tid = t;
    dbg_idx = r;
    #1 v = dbg_data;
  endtask

  // issue one instruction; lat = cycle index of done, counted from accept edge
  task automatic run(logic [31:0] ins, logic [TW-1:0] t, output int lat, output logic ill);
    @(negedge clk);
    in_valid = 1'b1;
    in_instr = ins;
    in_tid   = t;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1 in_valid = 1'b0;
    lat = 0;
    ill = 1'b0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      lat++;
      if (done) begin
        ill = illegal;
        break;
      end
    end
    @(posedge clk);
    #1;
  endtask

  // build a 32-bit value in a register from 6-bit constants
  task automatic load(logic [TW-1:0] t, logic [5:0] r, logic [31:0] v);
    int l;
    logic il;
    run(enc(8'h5B, 1'b1, 3'd0, r, 6'd0, r), t, l, il);
    run(enc(8'h5B, 1'b1, 3'd1, r, {4'd0, v[31:30]}, r), t, l, il);
    for (int k = 4; k >= 0; k--) begin
      run(enc(8'h5C, 1'b1, 3'd0, r, 6'd6, r), t, l, il);
      run(enc(8'h5B, 1'b1, 3'd1, r, v[6*k +: 6], r), t, l, il);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [108:0] e;
    logic [5:0] breg;
    int lat, explat;
    logic ill;
    string tag;

    rst_n = 1'b0; in_valid = 1'b0; in_instr = '0; in_tid = '0;
    dbg_tid = '0; dbg_idx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: reset state
    chk("R10 in_ready", 32'(in_ready), 32'd1);
    chk("R10 done", 32'(done), 32'd0);
    chk("R10 illegal", 32'(illegal), 32'd0);
    peek(1'b0, 6'd0, v);  chk("R10 t0 r0", v, 32'd0);
    peek(1'b1, 6'd63, v); chk("R10 t1 r63", v, 32'd0);

    // vector table: A in r8, B in r9 (same group) or r20, result in r33
    for (int i = 0; i < NV; i++) begin
      e = VEC[i];
      load(1'b0, 6'd8, e[95:64]);
      breg = e[96] ? 6'd9 : 6'd20;
      if (!e[97]) load(1'b0, breg, e[63:32]);
      run(enc(e[108:101], e[97], e[100:98], 6'd33, e[97] ? e[37:32] : breg, 6'd8),
          1'b0, lat, ill);
      if (e[108:101] == 8'h5B) tag = e[97] ? "R4 bitwise-const" : "R2 bitwise";
      else if (e[108:101] == 8'h5C) tag = "R3 shift";
      else tag = e[97] ? "R4 compare-const" : "R5 compare";
      peek(1'b0, 6'd33, v);
      chk(tag, v, e[31:0]);
      explat = (e[97] || e[96]) ? 3 : 4;
      chk("R6 latency", 32'(lat), 32'(explat));
      chk("R8 legal flag", 32'(ill), 32'd0);
      peek(1'b0, 6'd8, v);
      chk("R1 source A untouched", v, e[95:64]);
    end

    // R8: undefined selects and opcode leave registers alone
    load(1'b0, 6'd40, 32'h1234_5678);
    run(enc(8'h5B, 1'b0, 3'd3, 6'd40, 6'd8, 6'd8), 1'b0, lat, ill);
    chk("R8 bitwise sel3 flag", 32'(ill), 32'd1);
    peek(1'b0, 6'd40, v); chk("R8 bitwise sel3 no write", v, 32'h1234_5678);
    run(enc(8'h5C, 1'b1, 3'd2, 6'd40, 6'd1, 6'd8), 1'b0, lat, ill);
    chk("R8 shift sel2 flag", 32'(ill), 32'd1);
    peek(1'b0, 6'd40, v); chk("R8 shift sel2 no write", v, 32'h1234_5678);
    run(enc(8'h5D, 1'b1, 3'd5, 6'd40, 6'd1, 6'd8), 1'b0, lat, ill);
    chk("R8 compare sel5 flag", 32'(ill), 32'd1);
    run(enc(8'h5E, 1'b1, 3'd0, 6'd40, 6'd1, 6'd8), 1'b0, lat, ill);
    chk("R8 unknown opcode flag", 32'(ill), 32'd1);
    peek(1'b0, 6'd40, v); chk("R8 unknown opcode no write", v, 32'h1234_5678);

    // R9: thread banks are separate
    load(1'b1, 6'd33, 32'hCAFE_0001);
    peek(1'b1, 6'd33, v); chk("R9 t1 r33 written", v, 32'hCAFE_0001);
    peek(1'b0, 6'd40, v); chk("R9 t0 r40 kept", v, 32'h1234_5678);
    peek(1'b1, 6'd40, v); chk("R9 t1 r40 still zero", v, 32'd0);
    peek(1'b0, 6'd33, v); chk("R9 t0 r33 kept", v, VEC[NV-1][31:0]);

    // R7: back-to-back issue, second reads the first one's result
    @(negedge clk);
    in_valid = 1'b1; in_tid = 1'b0;
    in_instr = enc(8'h5B, 1'b1, 3'd1, 6'd50, 6'd5, 6'd0);   // r50 = r0 | 5
    @(posedge clk);
    #1 in_instr = enc(8'h5C, 1'b1, 3'd0, 6'd51, 6'd1, 6'd50); // r51 = r50 << 1
    @(negedge clk);
    chk("R7 not ready cycle1", 32'(in_ready), 32'd0);
    @(negedge clk);
    chk("R7 not ready cycle2", 32'(in_ready), 32'd0);
    @(negedge clk);
    chk("R7 done cycle3", 32'(done), 32'd1);
    chk("R7 ready on done", 32'(in_ready), 32'd1);
    @(posedge clk);
    #1 in_valid = 1'b0;
    lat = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      lat++;
      if (done) break;
    end
    chk("R6 back-to-back latency", 32'(lat), 32'd3);
    @(posedge clk);
    #1;
    peek(1'b0, 6'd51, v); chk("R7 forwarded result", v, 32'd10);

    // R10: a later reset clears written registers
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    peek(1'b0, 6'd40, v); chk("R10 t0 r40 cleared", v, 32'd0);
    peek(1'b1, 6'd33, v); chk("R10 t1 r33 cleared", v, 32'd0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule